// File: doc/BRIEF.md
# Register Rename Translation Matrix

This block holds the name mapping between architectural register numbers and renamed (virtual) register numbers as a crossbar of storage cells. Each row stands for one architectural register and each column for one virtual register. A set cell at row `r`, column `c` means that virtual register `c` currently stands for architectural register `r`. Two issue ports can each record a new mapping in the same cycle. Each port drives a one-hot row select and a one-hot column select, and the cell where they cross is set. A mapping is removed by a per-column clear. Each column holds at most one set cell, so one clear wire per column is enough to empty it.

Translation reuses the column select wires of issue port A. While `xl_en_i` is high, `set_a_col_i` selects the virtual register to look up, and port A records nothing in that cycle. Every cell's stored bit is ANDed with the enable and with its column select. The results are OR-reduced along each row, which gives a one-hot architectural row. That row is registered and appears on `xl_row_o` together with a hit flag. The block translates names only. Data movement, allocation and free-list policy belong to the logic around it, and so does the rule that no row or column ever holds two mappings.

A build-time option can interpret the low bits of the lookup select as a binary column index. In that variant the decoder is gated by the enable, so that columns which are not selected stay quiet.

Top module: `rename_matrix`

## Requirements
- R1: A synchronous active-high `rst` clears every mapping and the registered lookup outputs. Any lookup made after reset returns an all-zero row and `xl_hit_o` = 0.
- R2: Issue port B sets the cell where its one-hot `set_b_row_i` crosses its one-hot `set_b_col_i` at the rising edge. A lookup of that column in a later cycle returns that row.
- R3: Issue port A sets the cell where `set_a_row_i` crosses `set_a_col_i` in the same way, but only in cycles where `xl_en_i` is low.
- R4: Both ports can record mappings in the same cycle, each in its own cell. When both ports target the same cell, that cell is simply set.
- R5: A high bit `c` of `clr_col_i` empties column `c` at the edge. This takes priority over a set aimed at column `c` in the same cycle.
- R6: While `xl_en_i` is high, `set_a_col_i` acts as the one-hot lookup column. One cycle after the request, `xl_row_o` shows the one-hot row mapped to that column. Port A's row and column selects set no cell in that cycle.
- R7: A lookup of a column that holds no mapping returns `xl_row_o` = 0 and `xl_hit_o` = 0.
- R8: `xl_hit_o` equals the OR of `xl_row_o`. In the cycle after one in which `xl_en_i` is low, both outputs are zero.
- R9: A lookup returns the mapping held before the edge at which it is sampled. A set or clear of the same column in that cycle is visible only to later lookups.
- R10: When the surrounding logic respects the one-mapping-per-row and per-column rule, every lookup result is one-hot or zero and matches the mapping history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| set_a_row_i | input | NISA | Port A one-hot architectural row select |
| set_a_col_i | input | NVIRT | Port A one-hot virtual column select; lookup column while `xl_en_i` is high |
| set_b_row_i | input | NISA | Port B one-hot architectural row select |
| set_b_col_i | input | NVIRT | Port B one-hot virtual column select |
| clr_col_i | input | NVIRT | Per-column clear, one bit per virtual register |
| xl_en_i | input | 1 | Lookup request enable |
| xl_row_o | output | NISA | Registered one-hot translated architectural row |
| xl_hit_o | output | 1 | Registered flag: the looked-up column held a mapping |

## Verification
The hardest situation to reach is a lookup in the same cycle that a set or clear lands on the very column being looked up. Random traffic rarely lines these up. The stimulus therefore includes directed cycles that combine a lookup with a port B set, or with a clear of the same column, and then repeats the lookup to see the updated state. The suppression of port A during a lookup gets the same treatment: a lookup of an empty column carries a live row select, and a second lookup confirms that the column stayed empty. The random phase then draws free rows and columns from the bench's own map, so that every set respects the uniqueness rule, and it mixes clears of occupied columns with lookups.

// File: rtl/rm_pkg.sv
package rm_pkg;

    // How the lookup column select is presented on set_a_col_i
    typedef enum logic {
        SEL_ONEHOT = 1'b0,
        SEL_BINARY = 1'b1
    } sel_mode_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rm_sel_decode.sv
module rm_sel_decode
    import rm_pkg::*;
#(
    parameter int        NVIRT    = 16,
    parameter sel_mode_e SEL_MODE = SEL_ONEHOT
) (
    input  logic             en_i,
    input  logic [NVIRT-1:0] sel_i,
    output logic [NVIRT-1:0] col_hot_o
);

    localparam int IDXW = idx_width(NVIRT);

    generate
        if (SEL_MODE == SEL_ONEHOT) begin : g_onehot
            assign col_hot_o = en_i ? sel_i : '0;
        end else begin : g_binary
            // Enable gates each comparator so idle columns do not toggle
            for (genvar c = 0; c < NVIRT; c++) begin : g_col
                assign col_hot_o[c] = en_i && (sel_i[IDXW-1:0] == IDXW'(c));
            end
        end
    endgenerate

endmodule

// File: rtl/rm_cell_column.sv
module rm_cell_column #(
    parameter int NISA = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NISA-1:0] a_row_i,
    input  logic            a_hit_i,
    input  logic [NISA-1:0] b_row_i,
    input  logic            b_hit_i,
    input  logic            clr_i,
    output logic [NISA-1:0] bits_o
);

    logic [NISA-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (a_hit_i) set_vec = set_vec | a_row_i;
        if (b_hit_i) set_vec = set_vec | b_row_i;
    end

    // Clear outranks set on the same column
    always_ff @(posedge clk) begin
        if (rst || clr_i) bits_o <= '0;
        else              bits_o <= bits_o | set_vec;
    end

endmodule

// File: rtl/rm_row_or.sv
module rm_row_or #(
    parameter int NISA  = 8,
    parameter int NVIRT = 16
) (
    input  logic [NVIRT-1:0][NISA-1:0] cells_i,
    input  logic [NVIRT-1:0]           col_hot_i,
    output logic [NISA-1:0]            rows_o
);

    always_comb begin
        rows_o = '0;
        for (int c = 0; c < NVIRT; c++) begin
            rows_o = rows_o | (cells_i[c] & {NISA{col_hot_i[c]}});
        end
    end

endmodule

// File: rtl/rename_matrix.sv
module rename_matrix
    import rm_pkg::*;
#(
    parameter int        NISA     = 8,
    parameter int        NVIRT    = 16,
    parameter sel_mode_e SEL_MODE = SEL_ONEHOT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NISA-1:0]  set_a_row_i,
    input  logic [NVIRT-1:0] set_a_col_i,
    input  logic [NISA-1:0]  set_b_row_i,
    input  logic [NVIRT-1:0] set_b_col_i,
    input  logic [NVIRT-1:0] clr_col_i,
    input  logic             xl_en_i,
    output logic [NISA-1:0]  xl_row_o,
    output logic             xl_hit_o
);

    logic [NVIRT-1:0][NISA-1:0] cell_q;
    logic [NVIRT-1:0]           a_col_set;
    logic [NVIRT-1:0]           xl_col_hot;
    logic [NISA-1:0]            xl_rows;

    // Port A's column wires serve lookup while xl_en_i is high
    assign a_col_set = xl_en_i ? '0 : set_a_col_i;

    rm_sel_decode #(
        .NVIRT    (NVIRT),
        .SEL_MODE (SEL_MODE)
    ) u_dec (
        .en_i      (xl_en_i),
        .sel_i     (set_a_col_i),
        .col_hot_o (xl_col_hot)
    );

    generate
        for (genvar c = 0; c < NVIRT; c++) begin : g_col
            rm_cell_column #(
                .NISA (NISA)
            ) u_col (
                .clk     (clk),
                .rst     (rst),
                .a_row_i (set_a_row_i),
                .a_hit_i (a_col_set[c]),
                .b_row_i (set_b_row_i),
                .b_hit_i (set_b_col_i[c]),
                .clr_i   (clr_col_i[c]),
                .bits_o  (cell_q[c])
            );
        end
    endgenerate

    rm_row_or #(
        .NISA  (NISA),
        .NVIRT (NVIRT)
    ) u_or (
        .cells_i   (cell_q),
        .col_hot_i (xl_col_hot),
        .rows_o    (xl_rows)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xl_row_o <= '0;
            xl_hit_o <= 1'b0;
        end else begin
            xl_row_o <= xl_rows;
            xl_hit_o <= |xl_rows;
        end
    end

endmodule

// File: rtl/rename_matrix_chk.sv
module rename_matrix_chk #(
    parameter int NISA  = 8,
    parameter int NVIRT = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NISA-1:0]            set_a_row_i,
    input logic [NVIRT-1:0]           set_a_col_i,
    input logic [NISA-1:0]            set_b_row_i,
    input logic [NVIRT-1:0]           set_b_col_i,
    input logic [NVIRT-1:0]           clr_col_i,
    input logic                       xl_en_i,
    input logic [NVIRT-1:0][NISA-1:0] cell_q,
    input logic [NISA-1:0]            xl_row_o,
    input logic                       xl_hit_o
);

    // R1: reset empties the matrix and the result register
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (cell_q == '0) && (xl_row_o == '0) && !xl_hit_o);

    // R8: hit flag agrees with the row vector
    assert_hit_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        xl_hit_o |-> $onehot(xl_row_o));
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !xl_hit_o |-> (xl_row_o == '0));
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !xl_en_i |=> (xl_row_o == '0));

    generate
        for (genvar c = 0; c < NVIRT; c++) begin : g_c
            // R10: one mapping per column at most
            assert_col_unique_R10: assert property (@(posedge clk) disable iff (rst)
                $onehot0(cell_q[c]));
            // R5: clear wins over any set on its column
            assert_clear_col_R5: assert property (@(posedge clk) disable iff (rst)
                clr_col_i[c] |=> (cell_q[c] == '0));
            for (genvar r = 0; r < NISA; r++) begin : g_r
                // R2: port B crossing sets the cell
                assert_set_b_R2: assert property (@(posedge clk) disable iff (rst)
                    set_b_row_i[r] && set_b_col_i[c] && !clr_col_i[c] |=> cell_q[c][r]);
                // R6: port A sets nothing while a lookup is requested
                assert_a_quiet_R6: assert property (@(posedge clk) disable iff (rst)
                    xl_en_i && set_a_row_i[r] && set_a_col_i[c] && !cell_q[c][r]
                    && !(set_b_row_i[r] && set_b_col_i[c]) |=> !cell_q[c][r]);
            end
        end
        for (genvar r = 0; r < NISA; r++) begin : g_row
            logic [NVIRT-1:0] row_bits;
            always_comb begin
                for (int c = 0; c < NVIRT; c++) row_bits[c] = cell_q[c][r];
            end
            // R10: one mapping per row at most
            assert_row_unique_R10: assert property (@(posedge clk) disable iff (rst)
                $onehot0(row_bits));
        end
    endgenerate

endmodule

bind rename_matrix rename_matrix_chk #(
    .NISA  (NISA),
    .NVIRT (NVIRT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .set_a_row_i (set_a_row_i),
    .set_a_col_i (set_a_col_i),
    .set_b_row_i (set_b_row_i),
    .set_b_col_i (set_b_col_i),
    .clr_col_i   (clr_col_i),
    .xl_en_i     (xl_en_i),
    .cell_q      (cell_q),
    .xl_row_o    (xl_row_o),
    .xl_hit_o    (xl_hit_o)
);

// File: tb/rename_matrix_bench.sv
`timescale 1ns/1ps
module rename_matrix_bench;

    localparam int NISA  = 8;
    localparam int NVIRT = 16;

    typedef struct {
        logic [NISA-1:0] row;
        logic            hit;
        string           tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NISA-1:0]  set_a_row = '0;
    logic [NVIRT-1:0] set_a_col = '0;
    logic [NISA-1:0]  set_b_row = '0;
    logic [NVIRT-1:0] set_b_col = '0;
    logic [NVIRT-1:0] clr_col = '0;
    logic             xl_en = 1'b0;
    logic [NISA-1:0]  xl_row;
    logic             xl_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t exp_q[$];
    logic [NVIRT-1:0][NISA-1:0] mref = '0;

    always #2.5 clk = ~clk;

    rename_matrix #(.NISA(NISA), .NVIRT(NVIRT)) u_rename_matrix (
        .clk         (clk),
        .rst         (rst),
        .set_a_row_i (set_a_row),
        .set_a_col_i (set_a_col),
        .set_b_row_i (set_b_row),
        .set_b_col_i (set_b_col),
        .clr_col_i   (clr_col),
        .xl_en_i     (xl_en),
        .xl_row_o    (xl_row),
        .xl_hit_o    (xl_hit)
    );

    function automatic logic [NISA-1:0] ref_lookup(input logic [NVIRT-1:0] col);
        logic [NISA-1:0] r = '0;
        for (int c = 0; c < NVIRT; c++) if (col[c]) r = r | mref[c];
        return r;
    endfunction

    // Driver: one cycle of stimulus; pushes expected lookup results
    task automatic step(input logic [NISA-1:0] ar, input logic [NVIRT-1:0] ac,
                        input logic [NISA-1:0] br, input logic [NVIRT-1:0] bc,
                        input logic [NVIRT-1:0] clr, input logic en, input string tag);
        exp_t e;
        @(negedge clk);
        set_a_row = ar; set_a_col = ac; set_b_row = br; set_b_col = bc;
        clr_col = clr; xl_en = en;
        if (en) begin
            e.row = ref_lookup(ac);   // R9: state before this edge
            e.hit = |e.row;
            e.tag = tag;
            exp_q.push_back(e);
        end
        for (int c = 0; c < NVIRT; c++) begin
            if (clr[c]) mref[c] = '0;
            else begin
                if (!en && ac[c]) mref[c] = mref[c] | ar;
                if (bc[c])        mref[c] = mref[c] | br;
            end
        end
    endtask

    task automatic idle();
        step('0, '0, '0, '0, '0, 1'b0, "idle");
    endtask

    task automatic look(input int c, input string tag);
        step('0, NVIRT'(1) << c, '0, '0, '0, 1'b1, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; xl_en = 1'b0; set_a_col = '0; set_b_col = '0; clr_col = '0;
        mref = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Monitor: compares each registered result one edge after the request
    initial begin
        forever begin
            logic fire;
            exp_t e;
            @(posedge clk);
            fire = xl_en && !rst;
            #1;
            checks++;
            if (fire) begin
                e = exp_q.pop_front();
                if (xl_row !== e.row || xl_hit !== e.hit) begin
                    errors++;
                    $display("FAIL %s: row=%b hit=%b expected row=%b hit=%b",
                             e.tag, xl_row, xl_hit, e.row, e.hit);
                end
            end else if (xl_row !== '0 || xl_hit !== 1'b0) begin
                errors++;
                $display("FAIL R8/R1 idle: row=%b hit=%b expected row=0 hit=0",
                         xl_row, xl_hit);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 / R7: empty matrix after reset
        for (int c = 0; c < NVIRT; c++) look(c, "R1 R7 empty after reset");
        // R2: port B set
        step('0, '0, 8'h04, 16'h0020, '0, 1'b0, "R2 set");
        look(5, "R2 lookup c5");
        // R3: port A set
        step(8'h08, 16'h0080, '0, '0, '0, 1'b0, "R3 set");
        look(7, "R3 lookup c7");
        // R4: both ports, distinct cells, then same cell
        step(8'h01, 16'h0002, 8'h40, 16'h0200, '0, 1'b0, "R4 dual");
        look(1, "R4 lookup c1");
        look(9, "R4 lookup c9");
        step(8'h10, 16'h0010, 8'h10, 16'h0010, '0, 1'b0, "R4 same cell");
        look(4, "R4 lookup c4");
        // R5: clear beats a same-cycle set; plain clear
        step('0, '0, 8'h20, 16'h0020, 16'h0020, 1'b0, "R5 clr+set");
        look(5, "R5 c5 cleared");
        step('0, '0, '0, '0, 16'h0080, 1'b0, "R5 clr");
        look(7, "R5 c7 cleared");
        look(1, "R5 c1 untouched");
        // R6: port A selects ignored for setting during lookup
        step(8'h80, 16'h0400, '0, '0, '0, 1'b1, "R6 R7 lookup c10 empty");
        look(10, "R6 c10 still empty");
        // R9: lookup sees pre-edge state
        step(8'h00, 16'h0800, 8'h02, 16'h0800, '0, 1'b1, "R9 lookup during set");
        look(11, "R9 c11 after set");
        step('0, 16'h0010, '0, '0, 16'h0010, 1'b1, "R9 lookup during clr");
        look(4, "R9 c4 after clr");
        idle();
        // R1: reset with live mappings
        do_reset();
        look(1, "R1 c1 after reset");
        look(9, "R1 c9 after reset");
        look(11, "R1 c11 after reset");
        // R10: legal random traffic
        for (int i = 0; i < 600; i++) begin
            logic [NISA-1:0]  ar, br, used_r;
            logic [NVIRT-1:0] ac, bc, clr, used_c;
            logic en;
            ar = '0; ac = '0; br = '0; bc = '0; clr = '0;
            used_r = '0; used_c = '0;
            for (int c = 0; c < NVIRT; c++) begin
                used_r = used_r | mref[c];
                if (mref[c] != '0) used_c[c] = 1'b1;
            end
            en = ($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 3) == 0) clr[$urandom_range(0, NVIRT-1)] = 1'b1;
            if ($urandom_range(0, 1) == 1) begin
                for (int t = 0; t < 16; t++) begin
                    int r = $urandom_range(0, NISA-1);
                    int c = $urandom_range(0, NVIRT-1);
                    if (!used_r[r] && !used_c[c]) begin
                        br[r] = 1'b1; bc[c] = 1'b1;
                        used_r[r] = 1'b1; used_c[c] = 1'b1;
                        break;
                    end
                end
            end
            if (en) begin
                ac[$urandom_range(0, NVIRT-1)] = 1'b1;
                ar[$urandom_range(0, NISA-1)] = 1'b1;
            end else begin
                for (int t = 0; t < 16; t++) begin
                    int r = $urandom_range(0, NISA-1);
                    int c = $urandom_range(0, NVIRT-1);
                    if (!used_r[r] && !used_c[c]) begin
                        ar[r] = 1'b1; ac[c] = 1'b1;
                        break;
                    end
                end
            end
            step(ar, ac, br, bc, clr, en, "R10 random");
        end
        for (int c = 0; c < NVIRT; c++) look(c, "R10 final sweep");
        idle();
        idle();
        idle();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 scoreboard: %0d results missing, expected 0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule